// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer controlled over a plain 32-bit register bus (address, write strobe, write data, combinational read data). Software sets a prescaler divisor and a 16-bit reload count, arms the counter through a refresh register, and turns counting on or off through a start register. The timer advances only on a slow tick-enable input, which stands in for the low-frequency watchdog clock. When the count runs out, the block raises a reset request for exactly one clock cycle and then waits at zero until software reloads it.

Every write is guarded: it lands only if the upper half-word of the write data carries the unlock key 0x1234. The refresh register is split into three 2-bit groups. A group acts only when a write moves its value from 1 to 2 or from 2 to 1. Software can therefore read the register, XOR it with 0x3F and write it back to fire all three groups together. It can also flip a single group to fire only that one.

Top module: `keyed_wdt`

## Requirements
- R1: A write lands only when bus_wdata[31:16] equals 0x1234. Any other write changes no register and reloads nothing.
- R2: After reset the divisor field (bits 15:8 at offset 0x04) reads 0x0F, so the divisor is 16. The reload count (offset 0x08) reads 0xFFFF, the refresh register (offset 0x18) reads 0x15, the start register (offset 0x1C) reads 0, and rst_req is low.
- R3: A write to offset 0x04 stores the divisor minus one in bits 15:8. The counter keeps using the old divisor until the configuration group (refresh bits 5:4) fires.
- R4: A refresh group fires only when its value changes from 1 to 2 or from 2 to 1. A move to or from 0 or 3 does nothing.
- R5: With start bit 0 set, reload count N and divisor D, rst_req rises on the clock edge that samples the (N*D)-th tick-enable pulse counted after the reload and start.
- R6: rst_req is high for exactly one cycle. The counter then stays at zero with no further request until the reload group (refresh bits 3:2) fires.
- R7: Clearing start bit 0 freezes the counter and clears the prescaler phase. Setting the bit again continues from the frozen count.
- R8: Firing the phase group (refresh bits 1:0) restarts the prescaler, so a full D ticks pass before the next decrement.
- R9: Firing the reload group copies the reload count into the counter, taking priority over a decrement in the same cycle. It leaves the prescaler phase unchanged.
- R10: Offsets 0x04, 0x08, 0x18 and 0x1C read back their stored bits with zeros above them. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow watchdog tick enable |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data: key in bits 31:16, data in bits 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
On every cycle, the assertions check the key guard on all stored registers, the single-cycle width of the request, hold-at-zero after expiry, the freeze while stopped, the value loaded by a reload, and that the divisor changes only on refresh writes. The exact timeout, N*D ticks across a sweep of divisors, reload counts and tick spacings, can only be seen in the bench scenarios. So can the effects that depend on phase: a staged divisor being ignored, stop and resume, restarting the prescaler phase, and a reload in mid-count.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          ADDR_W   = 5,
  parameter int          CNT_W    = 16,
  parameter int          PRE_W    = 8,
  parameter logic [15:0] KEY      = 16'h1234,
  parameter logic [15:0] RST_CFG  = 16'h0F00,
  parameter logic [15:0] RST_LOAD = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_REFR  = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(5'h1C);
  localparam logic [5:0]        RST_REF = 6'h15;

  logic [15:0]      cfg_q, load_q;
  logic [5:0]       refr_q;
  logic             en_q;
  logic [PRE_W-1:0] div_q, pre_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic grp_flip(input logic [1:0] o, input logic [1:0] n);
    return (o == 2'd1 && n == 2'd2) || (o == 2'd2 && n == 2'd1);
  endfunction

  wire       wr_ok   = bus_we && (bus_wdata[31:16] == KEY);
  wire       wr_refr = wr_ok && (bus_addr == A_REFR);
  wire [5:0] ref_new = bus_wdata[5:0];
  wire       cfg_fire = wr_refr && grp_flip(refr_q[5:4], ref_new[5:4]);
  wire       rld_fire = wr_refr && grp_flip(refr_q[3:2], ref_new[3:2]);
  wire       ph_fire  = wr_refr && grp_flip(refr_q[1:0], ref_new[1:0]);
  wire       div_tick = en_q && tick_en && (pre_q == div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= RST_CFG;
      load_q <= RST_LOAD;
      refr_q <= RST_REF;
      en_q   <= 1'b0;
    end else if (wr_ok) begin
      if (bus_addr == A_CFG)   cfg_q  <= bus_wdata[15:0];
      if (bus_addr == A_LOAD)  load_q <= bus_wdata[15:0];
      if (bus_addr == A_REFR)  refr_q <= ref_new;
      if (bus_addr == A_START) en_q   <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= RST_CFG[15:8];
    else if (cfg_fire) div_q <= cfg_q[15:8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pre_q <= '0;
    else if (!en_q || ph_fire || cfg_fire)  pre_q <= '0;
    else if (tick_en)                       pre_q <= div_tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(RST_LOAD);
      rst_req <= 1'b0;
    end else begin
      rst_req <= div_tick && !rld_fire && (cnt_q == CNT_W'(1));
      if (rld_fire)                      cnt_q <= CNT_W'(load_q);
      else if (div_tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:   bus_rdata[15:0] = cfg_q;
      A_LOAD:  bus_rdata[15:0] = load_q;
      A_REFR:  bus_rdata[5:0]  = refr_q;
      A_START: bus_rdata[0]    = en_q;
      default: bus_rdata = '0;
    endcase
  end

  p_key_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata[31:16] != KEY) |=>
      ($stable(cfg_q) && $stable(load_q) && $stable(refr_q) && $stable(en_q)));

  p_div_staged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_REFR) |=> $stable(div_q));

  p_req_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en_q));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !rld_fire) |=> (cnt_q == '0 && !rst_req));

  p_stop_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !rld_fire) |=> $stable(cnt_q));

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rld_fire |=> (cnt_q == CNT_W'($past(load_q))));
endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0, failures = 0;
  bit tick_run = 1'b0, finished = 1'b0;
  int tick_per = 1, ph = 0;
  logic [5:0] ref_exp = 6'h15;
  localparam logic [15:0] K = 16'h1234;

  keyed_wdt u_keyed_wdt (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    ph = (ph + 1) % tick_per;
    tick_en <= tick_run && (ph == 0);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, logic [15:0] key = K);
    @(negedge clk);
    bus_addr = a; bus_wdata = {key, d}; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [4:0] a, output int v);
    @(negedge clk);
    bus_addr = a; #1 v = int'(bus_rdata);
  endtask

  task automatic refr(logic [5:0] flip);
    ref_exp = ref_exp ^ flip;
    wr(5'h18, {10'd0, ref_exp});
  endtask

  task automatic run_ticks(int k, output int reqs);
    int n = 0;
    reqs = 0;
    tick_run = 1'b1;
    while (n < k) begin
      @(posedge clk);
      if (tick_en) n++;
      if (n == k) tick_run = 1'b0;
      #1 if (rst_req) reqs++;
    end
    tick_run = 1'b0;
  endtask

  task automatic wait_req(output int n);
    bit seen = 1'b0;
    int guard = 0;
    n = 0;
    tick_run = 1'b1;
    while (!seen && guard < 4000) begin
      @(posedge clk);
      guard++;
      if (tick_en) n++;
      #1 if (rst_req) seen = 1'b1;
    end
    tick_run = 1'b0;
    if (!seen) n = -1;
    @(posedge clk);
    #1 chk("R6 pulse width", int'(rst_req), 0);
  endtask

  task automatic arm(int d, int nld);
    wr(5'h1C, 16'd0);
    wr(5'h04, 16'((d - 1) << 8));
    wr(5'h08, 16'(nld));
    refr(6'h3F);
    wr(5'h1C, 16'd1);
  endtask

  initial begin
    int v, n, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h04, v); chk("R2 cfg reset", (v >> 8) & 8'hFF, 8'h0F);
    rd(5'h08, v); chk("R2 load reset", v, 16'hFFFF);
    rd(5'h18, v); chk("R2 refresh reset", v, 6'h15);
    rd(5'h1C, v); chk("R2 start reset", v, 0);
    chk("R2 req reset", int'(rst_req), 0);

    wr(5'h08, 16'h0001, 16'h4321);
    rd(5'h08, v); chk("R1 bad key load", v, 16'hFFFF);
    wr(5'h1C, 16'h0001, 16'h0000);
    rd(5'h1C, v); chk("R1 bad key start", v, 0);

    // R3: divisor staged in cfg, only reload group fired -> old divisor 16
    wr(5'h04, 16'h0200);
    wr(5'h08, 16'd2);
    refr(6'h0C);
    wr(5'h1C, 16'd1);
    wait_req(n); chk("R3 staged divisor", n, 32);

    rd(5'h04, v); chk("R10 cfg readback", v, 16'h0200);
    rd(5'h08, v); chk("R10 load readback", v, 2);
    rd(5'h18, v); chk("R10 refresh readback", v, int'(ref_exp));
    rd(5'h1C, v); chk("R10 start readback", v, 1);
    rd(5'h10, v); chk("R10 unmapped read", v, 0);

    // R5 / R6 sweep: divisor, reload and tick spacing
    for (int p = 1; p <= 2; p++) begin
      tick_per = p;
      for (int d = 1; d <= 4; d++)
        for (int nl = 1; nl <= 4; nl++) begin
          arm(d, nl);
          wait_req(n); chk("R5 timeout ticks", n, nl * d);
          run_ticks(2 * nl * d + 2, r); chk("R6 hold at zero", r, 0);
        end
    end
    tick_per = 1;

    // R4: groups moving through 3 do not fire
    arm(2, 3);
    wait_req(n); chk("R5 timeout ticks", n, 6);
    ref_exp = ref_exp | 6'h0C; wr(5'h18, {10'd0, ref_exp});
    run_ticks(10, r); chk("R4 to 3 no reload", r, 0);
    ref_exp = (ref_exp & 6'h33) | 6'h04; wr(5'h18, {10'd0, ref_exp});
    run_ticks(10, r); chk("R4 3 to 1 no reload", r, 0);
    refr(6'h0C);
    wait_req(n); chk("R4 1 to 2 reloads", n, 6);

    // R1: bad-key refresh does not reload
    wr(5'h18, {10'd0, ref_exp ^ 6'h0C}, 16'h1235);
    run_ticks(10, r); chk("R1 bad key refresh", r, 0);

    // R7: stop freezes count and clears phase
    arm(2, 3);
    run_ticks(4, r);
    wr(5'h1C, 16'd0);
    run_ticks(10, r); chk("R7 stopped no req", r, 0);
    wr(5'h1C, 16'd1);
    wait_req(n); chk("R7 resume remaining", n, 2);

    // R8: phase group restarts prescaler
    arm(4, 2);
    run_ticks(3, r);
    refr(6'h03);
    wait_req(n); chk("R8 phase restart", n, 8);

    // R9: reload mid-count keeps prescaler phase
    arm(2, 3);
    run_ticks(5, r); chk("R9 no early req", r, 0);
    refr(6'h0C);
    wait_req(n); chk("R9 mid reload", n, 5);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule